// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Unit

This block holds the status byte of an instrument's remote-control port. It also holds an 8-bit enable mask that decides which summary bits may call the controller. Three bits of the byte carry live information. Bit 3 mirrors a summary input from the questionable-data event logic. Bit 5 mirrors a summary input from the standard event logic. Bit 4 is a message-available flag. The output queue sets it when a response is queued and clears it when the terminator has gone out to the host.

The bits that are set and also enabled are ORed into a summary-status signal. A request flag latches on a rising edge of that summary or on a front-panel strobe, and this flag drives the service request output. Two kinds of read return the byte with a different meaning in bit 6. A status query places the live summary there and leaves the request flag alone. A serial poll places the request flag there and then clears it.

Top module: `status_srq_unit`

## Requirements
- R1: Bits 0, 1, 2 and 7 of every byte returned by a read are 0.
- R2: In a read, bit 3 equals `ques_sum_i` and bit 5 equals `evt_sum_i` as sampled in the read cycle.
- R3: The message-available flag (bit 4) becomes 1 after a `resp_queued_i` strobe and 0 after a `term_sent_i` strobe. When both strobes arrive in the same cycle, the flag becomes 1.
- R4: A `mask_wr_i` cycle loads all 8 bits of `mask_data_i` into the enable mask. The summary status is 1 exactly when bit 3, 4 or 5 of the byte is 1 and the same mask bit is 1. Mask bits 0, 1, 2, 6 and 7 have no effect on the summary.
- R5: `srq_o` becomes 1 one clock after a `panel_req_i` strobe. It also becomes 1 one clock after the summary status goes from 0 to 1.
- R6: While the summary stays 1 after a serial poll has cleared the request flag, `srq_o` stays 0.
- R7: A query read (`query_rd_i`) returns the current summary status in bit 6. It does not change `srq_o`.
- R8: A serial poll (`poll_rd_i`) returns in bit 6 the value `srq_o` had in the poll cycle, and then clears `srq_o`. If a set event from R5 occurs in that same cycle, `srq_o` becomes 1.
- R9: When `poll_rd_i` and `query_rd_i` are both high in one cycle, the read is served as a serial poll.
- R10: `rd_valid_o` is high for exactly the one clock that follows each read strobe, and `rd_data_o` holds its value between reads.
- R11: A synchronous reset (`rst`) clears the mask, the message-available flag, the request flag, the summary history and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ques_sum_i | input | 1 | Questionable-data summary level |
| evt_sum_i | input | 1 | Standard event summary level |
| resp_queued_i | input | 1 | Strobe: response placed in output buffer |
| term_sent_i | input | 1 | Strobe: output terminator sent to host |
| panel_req_i | input | 1 | Strobe: front-panel service request |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| mask_data_i | input | 8 | Enable-mask write value |
| query_rd_i | input | 1 | Status-query read strobe |
| poll_rd_i | input | 1 | Serial-poll read strobe |
| rd_data_o | output | 8 | Byte returned by the latest read |
| rd_valid_o | output | 1 | One-clock pulse marking fresh `rd_data_o` |
| srq_o | output | 1 | Service request, equal to the request flag |

## Verification
The bench uses the default byte width of 8 and the fixed bit positions 3, 4, 5 and 6. Under these settings the enable masks 16, 48, 64 and 0xC7 probe each enabled bit and each ignored one. The stimulus produces two kinds of disagreement in bit 6. In one, a front-panel request raises the flag while the summary is 0. In the other, the summary stays high after a poll has cleared the flag. Both cases separate the query form from the poll form, and they also cover a poll that coincides with a new request.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int SB_W  = 8;
  localparam int B_QUES = 3;
  localparam int B_MAV  = 4;
  localparam int B_ESB  = 5;
  localparam int B_SUM  = 6;

  typedef logic [SB_W-1:0] sb_t;

  // Bits that may take part in the summary; everything else is masked off.
  localparam sb_t SRC_BITS = sb_t'((1 << B_QUES) | (1 << B_MAV) | (1 << B_ESB));

  function automatic sb_t pack_status(input logic ques, input logic mav, input logic esb);
    sb_t s;
    s = '0;
    s[B_QUES] = ques;
    s[B_MAV]  = mav;
    s[B_ESB]  = esb;
    return s;
  endfunction

  function automatic logic summary_of(input sb_t status, input sb_t mask);
    return |(status & mask & SRC_BITS);
  endfunction

  function automatic sb_t with_bit6(input sb_t status, input logic b6);
    sb_t s;
    s = status;
    s[B_SUM] = b6;
    return s;
  endfunction
endpackage

// File: rtl/ssb_mask_reg.sv
module ssb_mask_reg
  import ssb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  sb_t  wdata,
  output sb_t  mask
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= '0;
    else if (wr) mask <= wdata;
  end
endmodule

// File: rtl/ssb_msg_flag.sv
module ssb_msg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/ssb_rqs_ctrl.sv
module ssb_rqs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mss,
  input  logic panel_req,
  input  logic poll_rd,
  output logic mss_rise,
  output logic rqs
);
  logic mss_q;
  logic set_ev;

  assign mss_rise = mss & ~mss_q;
  assign set_ev   = mss_rise | panel_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mss_q <= 1'b0;
      rqs   <= 1'b0;
    end else begin
      mss_q <= mss;
      if (set_ev)       rqs <= 1'b1;
      else if (poll_rd) rqs <= 1'b0;
    end
  end
endmodule

// File: rtl/ssb_read_port.sv
module ssb_read_port
  import ssb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic query_rd,
  input  logic poll_rd,
  input  sb_t  status,
  input  logic mss,
  input  logic rqs,
  output sb_t  rd_data,
  output logic rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= query_rd | poll_rd;
      if (poll_rd)       rd_data <= with_bit6(status, rqs);
      else if (query_rd) rd_data <= with_bit6(status, mss);
    end
  end
endmodule

// File: rtl/status_srq_unit.sv
module status_srq_unit
  import ssb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ques_sum_i,
  input  logic            evt_sum_i,
  input  logic            resp_queued_i,
  input  logic            term_sent_i,
  input  logic            panel_req_i,
  input  logic            mask_wr_i,
  input  logic [SB_W-1:0] mask_data_i,
  input  logic            query_rd_i,
  input  logic            poll_rd_i,
  output logic [SB_W-1:0] rd_data_o,
  output logic            rd_valid_o,
  output logic            srq_o
);
  sb_t  mask_q;
  sb_t  status_w;
  logic mav;
  logic mss;
  logic mss_rise;
  logic rqs;

  ssb_mask_reg u_mask (
    .clk(clk), .rst(rst), .wr(mask_wr_i), .wdata(mask_data_i), .mask(mask_q)
  );

  ssb_msg_flag u_mav (
    .clk(clk), .rst(rst), .set_i(resp_queued_i), .clr_i(term_sent_i), .flag(mav)
  );

  assign status_w = pack_status(ques_sum_i, mav, evt_sum_i);
  assign mss      = summary_of(status_w, mask_q);

  ssb_rqs_ctrl u_rqs (
    .clk(clk), .rst(rst), .mss(mss), .panel_req(panel_req_i),
    .poll_rd(poll_rd_i), .mss_rise(mss_rise), .rqs(rqs)
  );

  ssb_read_port u_rd (
    .clk(clk), .rst(rst), .query_rd(query_rd_i), .poll_rd(poll_rd_i),
    .status(status_w), .mss(mss), .rqs(rqs),
    .rd_data(rd_data_o), .rd_valid(rd_valid_o)
  );

  assign srq_o = rqs;
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker
  import ssb_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      ques_sum_i,
  input logic      evt_sum_i,
  input logic      resp_queued_i,
  input logic      term_sent_i,
  input logic      panel_req_i,
  input logic      query_rd_i,
  input logic      poll_rd_i,
  input logic [SB_W-1:0] rd_data_o,
  input logic      rd_valid_o,
  input logic      srq_o,
  input logic      mav,
  input logic      mss,
  input logic      mss_rise,
  input logic [SB_W-1:0] mask_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (rd_data_o[2:0] == 3'b000 && rd_data_o[7] == 1'b0)); // R1
  AST_MAV_SET: assert property (@(posedge clk) disable iff (rst)
    resp_queued_i |=> mav); // R3
  AST_MAV_CLR: assert property (@(posedge clk) disable iff (rst)
    (term_sent_i && !resp_queued_i) |=> !mav); // R3
  AST_MASK_IGN: assert property (@(posedge clk) disable iff (rst)
    !((ques_sum_i && mask_q[3]) || (mav && mask_q[4]) || (evt_sum_i && mask_q[5])) |-> !mss); // R4
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    mss_rise |=> srq_o); // R5
  AST_PANEL_SETS: assert property (@(posedge clk) disable iff (rst)
    panel_req_i |=> srq_o); // R5
  AST_NO_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!srq_o && !mss_rise && !panel_req_i) |=> !srq_o); // R6
  AST_QUERY_B6: assert property (@(posedge clk) disable iff (rst)
    (query_rd_i && !poll_rd_i) |=> rd_data_o[6] == $past(mss)); // R7
  AST_HOLD_UNTIL_POLL: assert property (@(posedge clk) disable iff (rst)
    (srq_o && !poll_rd_i) |=> srq_o); // R7
  AST_POLL_B6: assert property (@(posedge clk) disable iff (rst)
    poll_rd_i |=> rd_data_o[6] == $past(srq_o)); // R8
  AST_POLL_CLR: assert property (@(posedge clk) disable iff (rst)
    (poll_rd_i && !mss_rise && !panel_req_i) |=> !srq_o); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (query_rd_i || poll_rd_i) |=> rd_valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(query_rd_i || poll_rd_i) |=> (!rd_valid_o && $stable(rd_data_o))); // R10
endmodule

bind status_srq_unit ssb_checker u_chk (
  .clk(clk), .rst(rst), .ques_sum_i(ques_sum_i), .evt_sum_i(evt_sum_i),
  .resp_queued_i(resp_queued_i), .term_sent_i(term_sent_i),
  .panel_req_i(panel_req_i), .query_rd_i(query_rd_i), .poll_rd_i(poll_rd_i),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .srq_o(srq_o),
  .mav(mav), .mss(mss), .mss_rise(mss_rise), .mask_q(mask_q)
);

// File: tb/tb_status_srq_unit.sv
`timescale 1ns/1ps
module tb_status_srq_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ques_sum_i = 1'b0, evt_sum_i = 1'b0;
  logic       resp_queued_i = 1'b0, term_sent_i = 1'b0, panel_req_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_data_i = 8'h00;
  logic       query_rd_i = 1'b0, poll_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o, srq_o;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  status_srq_unit dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: pops the scoreboard on every read result
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read", int'(rd_data_o), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data_o == e, t, int'(rd_data_o), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input bit q, input bit p, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    query_rd_i = q; poll_rd_i = p;
    tick(1);
    query_rd_i = 0; poll_rd_i = 0;
    tick(1);
  endtask

  task automatic wmask(input logic [7:0] v);
    mask_wr_i = 1; mask_data_i = v;
    tick(1);
    mask_wr_i = 0;
    tick(2);
  endtask

  task automatic strobe(input bit rq, input bit ts, input bit pr);
    resp_queued_i = rq; term_sent_i = ts; panel_req_i = pr;
    tick(1);
    resp_queued_i = 0; term_sent_i = 0; panel_req_i = 0;
    tick(2);
  endtask

  task automatic srq_is(input bit e, input string tag);
    check(srq_o == e, tag, int'(srq_o), int'(e));
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    srq_is(0, "R11 reset srq");
    check(rd_valid_o == 0 && rd_data_o == 0, "R11 reset read outputs", int'(rd_data_o), 0);

    rd(1, 0, 8'h00, "R1 idle query");
    ques_sum_i = 1; tick(1);
    rd(1, 0, 8'h08, "R2 ques bit, no enable");
    srq_is(0, "R4 disabled summary");

    wmask(8'h08);
    srq_is(1, "R5 summary rise");
    rd(1, 0, 8'h48, "R7 query shows summary");
    srq_is(1, "R7 query keeps flag");
    rd(0, 1, 8'h48, "R8 poll shows flag");
    srq_is(0, "R8 poll clears");
    tick(4);
    srq_is(0, "R6 no reassert while high");
    rd(1, 0, 8'h48, "R6 query still summary");
    rd(0, 1, 8'h08, "R6 poll flag clear");

    ques_sum_i = 0; tick(2); ques_sum_i = 1; tick(2);
    srq_is(1, "R5 new rising edge");
    rd(0, 1, 8'h48, "R8 poll after rise");

    strobe(1, 0, 0);
    rd(1, 0, 8'h58, "R3 mav set");
    srq_is(0, "R6 mav while summary high");
    strobe(0, 1, 0);
    rd(1, 0, 8'h48, "R3 mav cleared");
    ques_sum_i = 0; tick(1);
    wmask(8'd16);
    strobe(1, 0, 0);
    srq_is(1, "R5 mav enabled rise");
    rd(0, 1, 8'h50, "R8 poll mav");

    strobe(1, 1, 0);
    rd(1, 0, 8'h50, "R3 set wins");
    strobe(0, 1, 0);
    rd(1, 0, 8'h00, "R3 cleared again");

    wmask(8'd48);
    evt_sum_i = 1; tick(2);
    srq_is(1, "R5 esb enabled rise");
    rd(1, 0, 8'h60, "R2 esb query");
    rd(0, 1, 8'h60, "R8 esb poll");

    ques_sum_i = 1; tick(1);
    wmask(8'h40);
    rd(1, 0, 8'h28, "R4 mask bit6 ignored");
    srq_is(0, "R4 bit6 no request");
    wmask(8'hC7);
    rd(1, 0, 8'h28, "R4 reserved mask bits ignored");
    srq_is(0, "R4 reserved no request");

    strobe(0, 0, 1);
    srq_is(1, "R5 panel request");
    rd(1, 0, 8'h28, "R7 query summary zero");
    rd(0, 1, 8'h68, "R8 poll panel flag");
    srq_is(0, "R8 cleared after panel");

    panel_req_i = 1;
    rd(0, 1, 8'h28, "R8 poll with coincident set");
    panel_req_i = 0;
    srq_is(1, "R8 set wins over poll");
    rd(0, 1, 8'h68, "R8 second poll");

    strobe(0, 0, 1);
    rd(1, 1, 8'h68, "R9 poll wins");
    srq_is(0, "R9 flag cleared");

    wmask(8'h08);
    strobe(1, 0, 0);
    srq_is(1, "R11 pre-reset flag");
    rst = 1; tick(2); rst = 0; tick(1);
    srq_is(0, "R11 flag cleared");
    check(rd_data_o == 0, "R11 read data cleared", int'(rd_data_o), 0);
    rd(1, 0, 8'h28, "R11 mask and mav cleared");
    tick(3);
    srq_is(0, "R11 no request after reset");

    check(exp_q.size() == 0, "R10 missing reads", exp_q.size(), 0);
    report();
  end
endmodule